// File: doc/BRIEF.md
# Operand Specifier Decoder

This block takes a variable-length instruction one byte per cycle over a valid/ready handshake and decodes its operand specification. In wide mode an optional leading width-extension prefix byte (upper nibble 0100) adds a fourth, high bit to each register number. The prefix, if present, is followed by one opcode byte and then an operand selector byte. The selector byte either names a register directly or picks a memory form. A memory form may call for a scaled-index byte and a displacement of one or four bytes.

For memory forms, the block forms the effective address itself, after the last byte. It reads the base register and then the index register through a single combinational register-file read port. It then raises a one-cycle completion pulse with every output valid, and returns to wait for the next instruction.

States: `ST_IDLE` (first byte: prefix or opcode), `ST_OPCODE` (opcode after a prefix), `ST_SELECT` (operand selector byte), `ST_SCALED` (scaled-index byte), `ST_DISP` (displacement bytes), `ST_RD_BASE` (base read and displacement load), `ST_RD_INDEX` (scaled index added), `ST_FINISH` (completion pulse).

Transitions:
- `ST_IDLE` goes to `ST_OPCODE` on a prefix byte and to `ST_SELECT` otherwise.
- `ST_OPCODE` goes to `ST_SELECT`.
- `ST_SELECT` goes to `ST_FINISH` for register-direct forms. It goes to `ST_SCALED` when the scaled-index byte is needed, to `ST_DISP` when displacement follows, and to `ST_RD_BASE` otherwise.
- `ST_SCALED` goes to `ST_DISP` or `ST_RD_BASE`.
- `ST_DISP` goes to `ST_RD_BASE` after its last byte.
- `ST_RD_BASE` goes to `ST_RD_INDEX`, then to `ST_FINISH`, then back to `ST_IDLE`.

Top module: `opsel_decoder`

## Requirements
- R1: After reset, in_ready is 1 and done is 0.
- R2: With wide_mode=1, a first byte whose bits 7:4 equal 0100 is taken as a prefix. Its bits 2:0 are kept, and the next byte is always the opcode, whatever its value.
- R3: With wide_mode=0, every first byte, 0x40-0x4F included, is the opcode, and bit 3 of reg_num, base_num and index_num is 0.
- R4: The selector byte holds the mode in bits 7:6, the register field in bits 5:3 and the register/memory field in bits 2:0. ext_code equals the register field (0-7).
- R5: Prefix bit 2 becomes bit 3 of reg_num, bit 1 becomes bit 3 of index_num, and bit 0 becomes bit 3 of base_num. Without a prefix, these bits are 0.
- R6: Mode 11 is register-direct: base_num is the named register, is_mem is 0, eff_addr is 0, and no further byte is taken.
- R7: A scaled-index byte follows when mode is not 11 and bits 2:0 are 100. It holds scale in bits 7:6, index in 5:3 and base in 2:0, with eff_addr = base + (index << scale) + displacement.
- R8: An index code of 100 with prefix bit 1 clear means no index term. With prefix bit 1 set, it names register 12.
- R9: Mode 01 takes one sign-extended displacement byte, and mode 10 takes four bytes, least significant first. Mode 00 takes none, except when the base code (scaled-index base, or bits 2:0 without that byte) is 101. In that case there are four bytes and no base term.
- R10: For memory forms, in_ready is 0 from the last byte on. The base register is read, then the index register, on rf_addr, and done rises two cycles after the last byte; in_ready is 0 while done is 1.
- R11: done lasts exactly one cycle, and in_ready is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | Enables prefix recognition; hold steady within an instruction |
| in_valid | input | 1 | Instruction byte offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte taken when valid and ready |
| rf_addr | output | 4 | Register-file read address |
| rf_rdata | input | AW | Register-file read data, same cycle |
| done | output | 1 | One-cycle completion pulse |
| opcode | output | 8 | Opcode byte |
| reg_num | output | 4 | Register operand number |
| ext_code | output | 3 | Opcode-extension field |
| base_num | output | 4 | Direct register or memory base number |
| index_num | output | 4 | Index register number |
| is_mem | output | 1 | Memory operand form |
| eff_addr | output | AW | Effective address |

## Verification
The bench builds the block with AW=32, the default. At that width a four-byte displacement fills the whole address, and a negative one-byte displacement must sign-extend across all 32 bits. Base plus scaled index plus displacement can wrap modulo 2^32. Register values in the bench model are distinct per register, so a wrong base or index number or a wrong shift shows in the address.

// File: rtl/opsel_pkg.sv
package opsel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_SELECT,
        ST_SCALED,
        ST_DISP,
        ST_RD_BASE,
        ST_RD_INDEX,
        ST_FINISH
    } dec_state_e;

    localparam logic [3:0] PREFIX_NIBBLE = 4'b0100;
    localparam logic [1:0] MODE_DIRECT   = 2'b11;
    localparam logic [2:0] CODE_ESCAPE   = 3'b100;
    localparam logic [2:0] CODE_NO_BASE  = 3'b101;
    localparam logic [2:0] CODE_NO_INDEX = 3'b100;

    // number of displacement bytes for a memory mode and base code
    function automatic logic [2:0] disp_bytes(input logic [1:0] mode,
                                              input logic [2:0] base_code);
        logic [2:0] n;
        unique case (mode)
            2'b01:   n = 3'd1;
            2'b10:   n = 3'd4;
            2'b00:   n = (base_code == CODE_NO_BASE) ? 3'd4 : 3'd0;
            default: n = 3'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/opsel_ctrl.sv
module opsel_ctrl
    import opsel_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DISP_N = 4,
    localparam int DISP_W = BYTE_W * DISP_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output dec_state_e        state,
    output logic              start,
    output logic [BYTE_W-1:0] opcode,
    output logic [1:0]        mode,
    output logic [2:0]        reg3,
    output logic [2:0]        rm3,
    output logic [1:0]        scale,
    output logic [2:0]        idx3,
    output logic [2:0]        base3,
    output logic              has_sib,
    output logic [2:0]        pfx,
    output logic [DISP_W-1:0] disp
);

    dec_state_e nxt;
    logic       fire;
    logic       is_pfx;
    logic [2:0] dcnt;
    logic [2:0] dlen;

    assign in_ready = (state == ST_IDLE) || (state == ST_OPCODE) ||
                      (state == ST_SELECT) || (state == ST_SCALED) ||
                      (state == ST_DISP);
    assign fire   = in_valid && in_ready;
    assign is_pfx = wide_mode && (in_data[7:4] == PREFIX_NIBBLE);
    assign start  = fire && (state == ST_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (fire) nxt = is_pfx ? ST_OPCODE : ST_SELECT;
            ST_OPCODE: if (fire) nxt = ST_SELECT;
            ST_SELECT: if (fire) begin
                if (in_data[7:6] == MODE_DIRECT)        nxt = ST_FINISH;
                else if (in_data[2:0] == CODE_ESCAPE)   nxt = ST_SCALED;
                else if (disp_bytes(in_data[7:6], in_data[2:0]) != 3'd0)
                                                        nxt = ST_DISP;
                else                                    nxt = ST_RD_BASE;
            end
            ST_SCALED: if (fire)
                nxt = (disp_bytes(mode, in_data[2:0]) != 3'd0) ? ST_DISP : ST_RD_BASE;
            ST_DISP:   if (fire && (dcnt == dlen - 3'd1)) nxt = ST_RD_BASE;
            ST_RD_BASE:  nxt = ST_RD_INDEX;
            ST_RD_INDEX: nxt = ST_FINISH;
            ST_FINISH:   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode <= '0; mode <= '0; reg3 <= '0; rm3 <= '0;
            scale <= '0; idx3 <= '0; base3 <= '0; has_sib <= 1'b0;
            pfx <= '0; disp <= '0; dcnt <= '0; dlen <= '0;
        end else if (fire) begin
            unique case (state)
                ST_IDLE: begin
                    if (is_pfx) pfx <= in_data[2:0];
                    else begin
                        pfx    <= '0;
                        opcode <= in_data;
                    end
                end
                ST_OPCODE: opcode <= in_data;
                ST_SELECT: begin
                    mode    <= in_data[7:6];
                    reg3    <= in_data[5:3];
                    rm3     <= in_data[2:0];
                    has_sib <= (in_data[7:6] != MODE_DIRECT) &&
                               (in_data[2:0] == CODE_ESCAPE);
                    scale   <= '0;
                    idx3    <= '0;
                    base3   <= '0;
                    disp    <= '0;
                    dcnt    <= '0;
                    dlen    <= (in_data[7:6] == MODE_DIRECT) ? 3'd0 :
                               disp_bytes(in_data[7:6], in_data[2:0]);
                end
                ST_SCALED: begin
                    scale <= in_data[7:6];
                    idx3  <= in_data[5:3];
                    base3 <= in_data[2:0];
                    dlen  <= disp_bytes(mode, in_data[2:0]);
                end
                ST_DISP: begin
                    disp[BYTE_W*dcnt[1:0] +: BYTE_W] <= in_data;
                    dcnt <= dcnt + 3'd1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/opsel_agen.sv
module opsel_agen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld_base,
    input  logic          ld_index,
    input  logic          base_en,
    input  logic          index_en,
    input  logic [1:0]    scale,
    input  logic [AW-1:0] disp_ext,
    input  logic [AW-1:0] rdata,
    output logic [AW-1:0] ea
);

    logic [AW-1:0] scaled;

    assign scaled = rdata << scale;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ea <= '0;
        else if (clr)      ea <= '0;
        else if (ld_base)  ea <= disp_ext + (base_en ? rdata : '0);
        else if (ld_index) ea <= ea + (index_en ? scaled : '0);
    end

endmodule

// File: rtl/opsel_decoder.sv
module opsel_decoder
    import opsel_pkg::*;
#(
    parameter int AW = 32,
    localparam int BYTE_W = 8,
    localparam int DISP_N = 4,
    localparam int DISP_W = BYTE_W * DISP_N,
    localparam int RN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic [RN_W-1:0]   rf_addr,
    input  logic [AW-1:0]     rf_rdata,
    output logic              done,
    output logic [BYTE_W-1:0] opcode,
    output logic [RN_W-1:0]   reg_num,
    output logic [2:0]        ext_code,
    output logic [RN_W-1:0]   base_num,
    output logic [RN_W-1:0]   index_num,
    output logic              is_mem,
    output logic [AW-1:0]     eff_addr
);

    dec_state_e        state;
    logic              start;
    logic [1:0]        mode;
    logic [2:0]        reg3, rm3, idx3, base3, pfx, base_code;
    logic [1:0]        scale;
    logic              has_sib, base_en, index_en;
    logic [DISP_W-1:0] disp;
    logic [AW-1:0]     disp_ext;

    opsel_ctrl #(.BYTE_W(BYTE_W), .DISP_N(DISP_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .state(state), .start(start), .opcode(opcode), .mode(mode),
        .reg3(reg3), .rm3(rm3), .scale(scale), .idx3(idx3), .base3(base3),
        .has_sib(has_sib), .pfx(pfx), .disp(disp)
    );

    assign base_code = has_sib ? base3 : rm3;
    assign base_en   = !((mode == 2'b00) && (base_code == CODE_NO_BASE));
    assign index_en  = has_sib && !((idx3 == CODE_NO_INDEX) && !pfx[1]);
    assign disp_ext  = (mode == 2'b01) ? AW'($signed(disp[BYTE_W-1:0]))
                                       : AW'($signed(disp));

    always_comb begin
        reg_num   = {pfx[2], reg3};
        ext_code  = reg3;
        base_num  = {pfx[0], base_code};
        index_num = {pfx[1], idx3};
        is_mem    = (mode != MODE_DIRECT);
        done      = (state == ST_FINISH);
        rf_addr   = (state == ST_RD_INDEX) ? index_num : base_num;
    end

    opsel_agen #(.AW(AW)) u_agen (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .ld_base(state == ST_RD_BASE), .ld_index(state == ST_RD_INDEX),
        .base_en(base_en), .index_en(index_en), .scale(scale),
        .disp_ext(disp_ext), .rdata(rf_rdata), .ea(eff_addr)
    );

endmodule

// File: rtl/opsel_decoder_chk.sv
module opsel_decoder_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wide_mode,
    input logic          in_ready,
    input logic          done,
    input logic          is_mem,
    input logic [3:0]    reg_num,
    input logic [3:0]    base_num,
    input logic [3:0]    index_num,
    input logic [AW-1:0] eff_addr
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R11
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);                                        // R11
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);                                       // R10
    AST_DIRECT_ZERO_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_mem) |-> (eff_addr == '0));                   // R6
    AST_NARROW_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_mode) |-> (!reg_num[3] && !base_num[3] && !index_num[3])); // R3

endmodule

bind opsel_decoder opsel_decoder_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .in_ready(in_ready),
    .done(done), .is_mem(is_mem), .reg_num(reg_num), .base_num(base_num),
    .index_num(index_num), .eff_addr(eff_addr)
);

// File: tb/opsel_decoder_bench.sv
`timescale 1ns/1ps
module opsel_decoder_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wide_mode = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready, done, is_mem;
    logic [3:0]    rf_addr, reg_num, base_num, index_num;
    logic [2:0]    ext_code;
    logic [7:0]    opcode;
    logic [AW-1:0] rf_rdata, eff_addr;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string      tag;
        logic [7:0] op;
        logic [3:0] rn;
        logic [2:0] ext;
        logic [3:0] bn;
        logic       chk_idx;
        logic [3:0] xn;
        logic       mem;
        logic [31:0] ea;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] rv(input logic [3:0] i);
        return 32'h1000 * (32'(i) + 1) + 32'(i) * 7;
    endfunction

    assign rf_rdata = rv(rf_addr);

    opsel_decoder #(.AW(AW)) u_opsel_decoder (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .rf_addr(rf_addr),
        .rf_rdata(rf_rdata), .done(done), .opcode(opcode), .reg_num(reg_num),
        .ext_code(ext_code), .base_num(base_num), .index_num(index_num),
        .is_mem(is_mem), .eff_addr(eff_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input int gap);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic instr(input string tag, input logic wide, input logic hp,
                         input logic [7:0] p, input logic [7:0] op,
                         input logic [7:0] sel, input logic hs, input logic [7:0] s,
                         input int nd, input logic [31:0] d, input int gap);
        exp_t e;
        logic [2:0] pv, bc;
        logic [3:0] bn, xn;
        logic [31:0] de;
        logic hb, hi;
        pv = hp ? p[2:0] : 3'b000;
        bc = hs ? s[2:0] : sel[2:0];
        bn = {pv[0], bc};
        xn = {pv[1], s[5:3]};
        hb = !(sel[7:6] == 2'b00 && bc == 3'b101);
        hi = hs && !(s[5:3] == 3'b100 && !pv[1]);
        de = (nd == 1) ? {{24{d[7]}}, d[7:0]} : (nd == 4) ? d : 32'h0;
        e.tag = tag; e.op = op; e.rn = {pv[2], sel[5:3]}; e.ext = sel[5:3];
        e.bn = bn; e.chk_idx = hs; e.xn = xn;
        e.mem = (sel[7:6] != 2'b11);
        e.ea  = !e.mem ? 32'h0 :
                (hb ? rv(bn) : 32'h0) + (hi ? (rv(xn) << s[7:6]) : 32'h0) + de;
        sb.push_back(e);
        wide_mode = wide;
        if (hp) send(p, gap);
        send(op, gap);
        send(sel, gap);
        if (hs) send(s, gap);
        for (int k = 0; k < nd; k++) send(d[8*k +: 8], gap);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) chk("R11 ready after done", 32'(in_ready), 32'd1);
            if (done) begin
                if (sb.size() == 0) chk("R11 unexpected done", 32'd1, 32'd0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.tag, " R10 ready low at done"}, 32'(in_ready), 32'd0);
                    chk({e.tag, " R2/R3 opcode"}, 32'(opcode), 32'(e.op));
                    chk({e.tag, " R5 reg_num"}, 32'(reg_num), 32'(e.rn));
                    chk({e.tag, " R4 ext_code"}, 32'(ext_code), 32'(e.ext));
                    chk({e.tag, " R5 base_num"}, 32'(base_num), 32'(e.bn));
                    if (e.chk_idx) chk({e.tag, " R8 index_num"}, 32'(index_num), 32'(e.xn));
                    chk({e.tag, " R6 is_mem"}, 32'(is_mem), 32'(e.mem));
                    chk({e.tag, " R7 eff_addr"}, eff_addr, e.ea);
                end
            end
            prev_done <= done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ready", 32'(in_ready), 32'd1);
        chk("R1 reset done", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(in_ready), 32'd1);
        // R6 register-direct, no prefix
        instr("R6 direct", 0, 0, 8'h00, 8'h01, 8'hC8, 0, 8'h00, 0, 0, 0);
        // R2 R5 prefix widens reg and base
        instr("R2 prefix", 1, 1, 8'h45, 8'h89, 8'hC8, 0, 8'h00, 0, 0, 0);
        // R2 second byte is opcode even if 0x4X
        instr("R2 opcode 4X", 1, 1, 8'h41, 8'h48, 8'hC0, 0, 8'h00, 0, 0, 0);
        // R3 narrow mode: 0x45 is the opcode
        instr("R3 narrow", 0, 0, 8'h00, 8'h45, 8'hD3, 0, 8'h00, 0, 0, 0);
        // R9 mode 00 no displacement
        instr("R9 base only", 0, 0, 8'h00, 8'h8B, 8'h03, 0, 8'h00, 0, 0, 0);
        // R9 mode 01 negative byte, R4 ext 6
        instr("R9 disp8", 0, 0, 8'h00, 8'h8B, 8'h76, 0, 8'h00, 1, 32'hF0, 0);
        // R9 mode 10 four bytes
        instr("R9 disp32", 0, 0, 8'h00, 8'h8B, 8'h81, 0, 8'h00, 4, 32'h12345678, 0);
        // R9 mode 00 code 101 no base
        instr("R9 absolute", 0, 0, 8'h00, 8'h8B, 8'h05, 0, 8'h00, 4, 32'h00400000, 0);
        // R7 scaled index x4
        instr("R7 sib", 0, 0, 8'h00, 8'h8B, 8'h04, 1, 8'h8A, 0, 0, 0);
        // R8 index 100 means none
        instr("R8 no index", 0, 0, 8'h00, 8'h8B, 8'h04, 1, 8'h63, 0, 0, 0);
        // R8 prefix bit1 makes index 12, scale 8
        instr("R8 index12", 1, 1, 8'h42, 8'h8B, 8'h44, 1, 8'hE0, 1, 32'h10, 0);
        // R9 scaled byte base 101 in mode 00
        instr("R9 sib nobase", 0, 0, 8'h00, 8'h8B, 8'h04, 1, 8'h4D, 4, 32'h1000, 0);
        // R5 R10 prefix base extension, stalled bytes
        instr("R10 gaps", 1, 1, 8'h41, 8'h8B, 8'h84, 1, 8'h1B, 4, 32'hFFFF0000, 2);
        // R4 R5 ext and wide reg
        instr("R4 ext", 1, 1, 8'h44, 8'hFF, 8'hE8, 0, 8'h00, 0, 0, 0);
        // R2 wide mode without prefix byte
        instr("R2 no prefix", 1, 0, 8'h00, 8'h8B, 8'h1C, 1, 8'h5E, 0, 0, 0);
        repeat (4) @(negedge clk);
        if (sb.size() != 0) chk("R10 pending results", 32'(sb.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule